// File: doc/BRIEF.md
# Systolic Pipelined FIR Filter

This block is a fully parallel 31-tap finite impulse response filter that takes one new sample on every clock and produces one filtered result on every clock. Each tap has its own multiplier. Incoming samples step through a chain of local registers, so every multiplier is fed from a nearby flop and no single input net has to reach all taps. Partial sums move from tap to tap along a registered adder chain. The sum leaving the last tap is the filter output.

Samples arrive on a stream with a qualifier. A cycle whose qualifier is low is treated as a zero sample, so the filter always advances one slot per clock. Coefficients sit in a bank of registers written one entry at a time. The bank is meant to be loaded while no non-zero samples are in flight. The output qualifier follows the input qualifier through the same fixed latency and stays low until the delay line has been filled once after reset.

Top module: `systolic_fir`

## Requirements
- R1: While `rst` is high, and for every cycle after reset before the first result arrives, `out_valid` is 0 and `out_data` is 0. Reset is synchronous and active high, and it also clears the coefficient bank to zero.
- R2: Slot n counts clock edges from the first edge with `rst` low, starting at slot 0. The input x[n] of slot n is `in_sample` when `in_valid` is 1 and zero otherwise. The result is y[n] = sum over i = 0..30 of h[i]·x[n−i], with x at negative indices equal to zero. Both x and h are two's complement.
- R3: The result y[n] is on `out_data` exactly 33 clock edges (NTAPS+2) after the edge that captured slot n.
- R4: The `out_valid` flag that goes with y[n] is 1 only when `in_valid` was 1 in slot n and n ≥ 30 (NTAPS−1). The first 30 slots after reset never produce a valid result.
- R5: The output is a 37-bit two's-complement value (16+16 bits plus 5 bits of growth). It is exact, with no rounding or saturation, even when every product is at its most negative or most positive value.
- R6: When `coef_we` is 1 and `coef_addr` < 31, `coef_data` is stored as h[`coef_addr`] at that clock edge. All later samples are filtered with the new value.
- R7: A write with `coef_addr` ≥ 31 (the only such 5-bit value is 31) changes no coefficient.
- R8: A single non-zero sample v surrounded by zero slots yields the results h[0]·v, h[1]·v, … h[30]·v on consecutive clocks, in tap-index order. Tap 1 sees each gated sample three cycles after it was presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample qualifier; low means a zero sample |
| in_sample | input | 16 | Signed input sample |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 5 | Tap index of the coefficient write |
| coef_data | input | 16 | Signed coefficient value |
| out_valid | output | 1 | Result qualifier |
| out_data | output | 37 | Signed filter result |

## Verification
A wrong sample register in the delay chain misaligns one tap against its partial sum. The fault shows at `out_data` 33 cycles after the first non-zero sample that reaches that tap, as a result that is off by that tap's term. A broken adder-chain stage or product register corrupts every later result once data flows. A faulty qualifier shift register or slot counter shows on `out_valid` at the end of the first fill, or as a flag that lands one cycle early or late. Comparing with a behavioural convolution model on every clock therefore catches these faults within one pipeline latency of the stimulus that exposes them.

// File: rtl/fir_pkg.sv
package fir_pkg;

  // Bits needed to hold the sum of n full-scale products without overflow.
  function automatic int growth_bits(int n);
    return $clog2(n);
  endfunction

  // Width of a chain partial sum for given sample and coefficient widths.
  function automatic int chain_width(int dw, int cw, int n);
    return dw + cw + growth_bits(n);
  endfunction

  // Address width for a bank with n entries.
  function automatic int index_width(int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/fir_coef_bank.sv
module fir_coef_bank #(
  parameter int NTAPS = 31,
  parameter int CW    = 16,
  parameter int AW    = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_idx,
  input  logic signed [CW-1:0] wr_val,
  output logic signed [CW-1:0] weights [NTAPS]
);

  logic idx_ok;
  assign idx_ok = (32'(wr_idx) < NTAPS);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NTAPS; k++) weights[k] <= '0;
    end else if (wr_en && idx_ok) begin
      weights[wr_idx] <= wr_val;
    end
  end

endmodule

// File: rtl/fir_tap.sv
module fir_tap #(
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int SW = 37
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [DW-1:0] smp_in,
  input  logic signed [CW-1:0] weight,
  input  logic signed [SW-1:0] acc_in,
  output logic signed [DW-1:0] smp_here,
  output logic signed [DW-1:0] smp_out,
  output logic signed [SW-1:0] acc_out
);

  localparam int PW = DW + CW;

  logic signed [DW-1:0] smp_a, smp_b;
  logic signed [PW-1:0] prod_q;

  function automatic logic signed [PW-1:0] mul(input logic signed [DW-1:0] a,
                                               input logic signed [CW-1:0] b);
    logic signed [PW-1:0] wa, wb;
    wa = PW'(a);
    wb = PW'(b);
    return wa * wb;
  endfunction

  function automatic logic signed [SW-1:0] accumulate(input logic signed [SW-1:0] s,
                                                      input logic signed [PW-1:0] p);
    logic signed [SW-1:0] wp;
    wp = SW'(p);
    return s + wp;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_a   <= '0;
      smp_b   <= '0;
      prod_q  <= '0;
      acc_out <= '0;
    end else begin
      smp_a   <= smp_in;
      smp_b   <= smp_a;
      prod_q  <= mul(smp_a, weight);
      acc_out <= accumulate(acc_in, prod_q);
    end
  end

  assign smp_here = smp_a;
  assign smp_out  = smp_b;

endmodule

// File: rtl/fir_valid_track.sv
module fir_valid_track #(
  parameter int NTAPS = 31,
  parameter int LAT   = 33
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  output logic out_valid
);

  localparam int CNTW = (NTAPS > 1) ? $clog2(NTAPS) : 1;
  localparam logic [CNTW-1:0] FULL = CNTW'(NTAPS - 1);

  logic [CNTW-1:0] slot_cnt;
  logic [LAT-1:0]  flag_sr;
  logic            primed;
  logic            slot_ok;

  assign primed  = (slot_cnt == FULL);
  assign slot_ok = in_valid && primed;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_cnt <= '0;
      flag_sr  <= '0;
    end else begin
      if (!primed) slot_cnt <= slot_cnt + 1'b1;
      flag_sr <= {flag_sr[LAT-2:0], slot_ok};
    end
  end

  assign out_valid = flag_sr[LAT-1];

endmodule

// File: rtl/systolic_fir.sv
module systolic_fir #(
  parameter int NTAPS = 31,
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int AW    = fir_pkg::index_width(NTAPS),
  parameter int SW    = fir_pkg::chain_width(DW, CW, NTAPS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_sample,
  input  logic                 coef_we,
  input  logic [AW-1:0]        coef_addr,
  input  logic signed [CW-1:0] coef_data,
  output logic                 out_valid,
  output logic signed [SW-1:0] out_data
);

  localparam int LAT = NTAPS + 2;
  localparam int T1  = (NTAPS > 1) ? 1 : 0;

  logic signed [CW-1:0] weights  [NTAPS];
  logic signed [DW-1:0] smp_link [NTAPS+1];
  logic signed [DW-1:0] smp_tap  [NTAPS];
  logic signed [SW-1:0] acc_link [NTAPS+1];

  // Named internal events for the checker.
  logic signed [DW-1:0] x_gated;
  logic signed [DW-1:0] tap1_smp;
  logic signed [CW-1:0] coef0;
  logic signed [SW-1:0] sum0;

  assign x_gated     = in_valid ? in_sample : '0;
  assign smp_link[0] = x_gated;
  assign acc_link[0] = '0;

  fir_coef_bank #(.NTAPS(NTAPS), .CW(CW), .AW(AW)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (coef_we),
    .wr_idx  (coef_addr),
    .wr_val  (coef_data),
    .weights (weights)
  );

  for (genvar i = 0; i < NTAPS; i++) begin : g_tap
    fir_tap #(.DW(DW), .CW(CW), .SW(SW)) u_tap (
      .clk      (clk),
      .rst      (rst),
      .smp_in   (smp_link[i]),
      .weight   (weights[i]),
      .acc_in   (acc_link[i]),
      .smp_here (smp_tap[i]),
      .smp_out  (smp_link[i+1]),
      .acc_out  (acc_link[i+1])
    );
  end

  fir_valid_track #(.NTAPS(NTAPS), .LAT(LAT)) u_vld (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid)
  );

  assign out_data = acc_link[NTAPS];
  assign tap1_smp = smp_tap[T1];
  assign coef0    = weights[0];
  assign sum0     = acc_link[1];

endmodule

// File: rtl/systolic_fir_checker.sv
module systolic_fir_checker #(
  parameter int NTAPS = 31,
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int SW    = 37
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic signed [DW-1:0] x_gated,
  input logic signed [DW-1:0] tap1_smp,
  input logic signed [CW-1:0] coef0,
  input logic signed [SW-1:0] sum0,
  input logic                 out_valid,
  input logic signed [SW-1:0] out_data
);

  localparam int LAT   = NTAPS + 2;
  localparam int CYMAX = NTAPS + LAT;
  localparam int CYW   = $clog2(CYMAX + 1) + 1;
  localparam int IDW   = $clog2(LAT + 1) + 1;

  logic [CYW-1:0] cyc;
  logic [IDW-1:0] idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc  <= '0;
      idle <= IDW'(LAT);
    end else begin
      if (cyc != CYW'(CYMAX)) cyc <= cyc + 1'b1;
      if (in_valid)                 idle <= '0;
      else if (idle != IDW'(LAT))   idle <= idle + 1'b1;
    end
  end

  AST_FILL_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cyc < CYW'(LAT)) |-> (out_data == '0)); // R1

  AST_FIRST_TERM: assert property (@(posedge clk) disable iff (rst)
    (cyc >= CYW'(4)) |-> (sum0 == $past(coef0, 2) * $past(x_gated, 3))); // R2

  AST_PRIME_WAIT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (cyc >= CYW'(NTAPS + LAT - 1))); // R4

  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (idle < IDW'(LAT))); // R4

  AST_LOCAL_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    (cyc >= CYW'(4)) |-> (tap1_smp == $past(x_gated, 3))); // R8

endmodule

bind systolic_fir systolic_fir_checker #(
  .NTAPS(NTAPS), .DW(DW), .CW(CW), .SW(SW)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .x_gated   (x_gated),
  .tap1_smp  (tap1_smp),
  .coef0     (coef0),
  .sum0      (sum0),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/tb_systolic_fir.sv
module tb_systolic_fir;

  localparam int N   = 31;
  localparam int LAT = 33;
  localparam int DW  = 16;
  localparam int CW  = 16;
  localparam int SW  = 37;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 in_valid = 1'b0;
  logic signed [DW-1:0] in_sample = '0;
  logic                 coef_we = 1'b0;
  logic [4:0]           coef_addr = '0;
  logic signed [CW-1:0] coef_data = '0;
  logic                 out_valid;
  logic signed [SW-1:0] out_data;

  always #10 clk = ~clk;

  systolic_fir dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .coef_we(coef_we), .coef_addr(coef_addr), .coef_data(coef_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  int     n_chk = 0;
  int     n_bad = 0;
  bit     done  = 1'b0;
  string  phase = "R1";
  longint h [N];
  longint xq [$];
  bit     evq [$];
  longint edq [$];
  int     slot;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic model_push(input bit v, input longint s);
    longint y;
    xq.push_front(v ? s : 0);
    if (xq.size() > N) void'(xq.pop_back());
    y = 0;
    for (int i = 0; i < xq.size(); i++) y += h[i] * xq[i];
    evq.push_back(v && (slot >= N - 1));
    edq.push_back(y);
    slot++;
  endtask

  task automatic observe();
    bit     ev;
    longint ed;
    ev = evq.pop_front();
    ed = edq.pop_front();
    check(out_valid === ev, {phase, " out_valid"}, longint'(out_valid), longint'(ev));
    check(longint'(out_data) === ed, {phase, " out_data"}, longint'(out_data), ed);
  endtask

  task automatic step(input bit v, input longint s);
    @(negedge clk);
    observe();
    in_valid  = v;
    in_sample = DW'(s);
    coef_we   = 1'b0;
    model_push(v, s);
  endtask

  task automatic wcoef(input int a, input longint d);
    @(negedge clk);
    observe();
    in_valid  = 1'b0;
    in_sample = '0;
    coef_we   = 1'b1;
    coef_addr = 5'(a);
    coef_data = CW'(d);
    if (a < N) h[a] = d;
    model_push(1'b0, 0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    coef_we = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R1 reset out_valid", longint'(out_valid), 0);
    check(out_data === '0, "R1 reset out_data", longint'(out_data), 0);
    for (int i = 0; i < N; i++) h[i] = 0;
    xq.delete(); evq.delete(); edq.delete();
    slot = 0;
    for (int i = 0; i < LAT - 1; i++) begin
      evq.push_back(1'b0);
      edq.push_back(0);
    end
    rst = 1'b0;
    model_push(1'b0, 0);
  endtask

  initial begin
    int m;
    do_reset();

    // R4: priming with a continuous valid stream, zero coefficients
    phase = "R4";
    for (int i = 0; i < 60; i++) step(1'b1, longint'($urandom_range(0, 2000)) - 1000);
    idle(40);

    // R6: load a ramp of coefficients
    phase = "R6";
    for (int i = 0; i < N; i++) wcoef(i, i + 1);
    idle(70);

    // R8: impulse response in tap order
    phase = "R8";
    step(1'b1, 3);
    idle(70);

    // R3: latency of a lone sample
    phase = "R3";
    step(1'b1, 5);
    m = 0;
    for (int i = 1; i <= 100; i++) begin
      step(1'b0, 0);
      if (out_valid === 1'b1 && m == 0) m = i;
    end
    check(m == LAT, "R3 latency", m, LAT);

    // R6: reload with mixed-sign coefficients, then R2 random stream with gaps
    phase = "R6";
    for (int i = 0; i < N; i++) wcoef(i, longint'($urandom_range(0, 65535)) - 32768);
    phase = "R2";
    for (int i = 0; i < 600; i++)
      step(($urandom_range(0, 9) < 7), longint'($urandom_range(0, 65535)) - 32768);
    idle(70);

    // R5: extreme negative products
    phase = "R5";
    for (int i = 0; i < N; i++) wcoef(i, -32768);
    idle(70);
    for (int i = 0; i < 70; i++) step(1'b1, -32768);
    check(longint'(out_data) == 64'sd31 * 64'sd1073741824, "R5 max positive",
          longint'(out_data), 64'sd31 * 64'sd1073741824);
    idle(70);
    for (int i = 0; i < N; i++) wcoef(i, 32767);
    idle(70);
    for (int i = 0; i < 70; i++) step(1'b1, -32768);
    check(longint'(out_data) == -64'sd31 * 64'sd32767 * 64'sd32768, "R5 max negative",
          longint'(out_data), -64'sd31 * 64'sd32767 * 64'sd32768);
    idle(70);

    // R7: out-of-range write leaves the bank unchanged
    phase = "R6";
    for (int i = 0; i < N; i++) wcoef(i, 100 - 7 * i);
    idle(70);
    phase = "R7";
    wcoef(31, 12345);
    idle(5);
    step(1'b1, -2);
    idle(70);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

endmodule